// File: doc/BRIEF.md
# Virtual CPU Interface Maintenance Status

This block produces the maintenance status word that a hypervisor reads for one virtual CPU interface. Each status bit is not a latched event. It is a qualified condition evaluated afresh every cycle from three things: the hypervisor's per-condition enables, the guest's Group 0 and Group 1 enable bits, and the live state of the list registers. The block also evaluates the end-of-interrupt status vector and an end-of-interrupt count field.

The evaluated word is registered. Software reads it through a small memory-mapped read port at byte offset 0x010. A single maintenance interrupt line is raised while any status bit is set and the global enable is on. Writing the list registers and producing the end-of-interrupt vector are handled elsewhere.

Top module: `vmaint_status`

## Requirements
- R1: Bits 31:8 of the status word, and of every read response, are always zero.
- R2: Bit 7 is 1 when `en_g1_off` is 1 and `vm_grp1_on` is 0. Bit 6 is 1 when `en_g1_on` is 1 and `vm_grp1_on` is 1.
- R3: Bit 5 is 1 when `en_g0_off` is 1 and `vm_grp0_on` is 0. Bit 4 is 1 when `en_g0_on` is 1 and `vm_grp0_on` is 1.
- R4: Each list entry is a 2-bit field in `lr_state[2*i+1:2*i]`, encoded 00 invalid, 01 pending, 10 active, 11 active-and-pending. Bit 3 is 1 when `en_nopend` is 1 and no entry holds 01. An entry holding 11 does not count as pending.
- R5: Bit 2 is 1 when `en_lr_absent` is 1 and `eoi_count` is nonzero.
- R6: Bit 1 is 1 when `en_underflow` is 1 and at most one entry is valid. An entry is valid when its field is not 00, and zero valid entries also qualify.
- R7: Bit 0 is 1 when any bit of `eoi_status` is 1. This bit has no enable.
- R8: `maint_irq` is 1 only when `glob_en` is 1 and at least one status bit is 1.
- R9: A read with `bus_rd`=1 at `bus_addr`=0x010 returns the registered status word on `rd_data` in the following cycle. A read at any other offset returns zero, and so does a cycle with no read.
- R10: A write (`bus_wr`=1 with any `bus_wdata`) at any offset, 0x010 included, has no effect on the status word.
- R11: Status and `maint_irq` are registered. They are cleared by synchronous active-high `rst` and follow an input change after one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glob_en | input | 1 | Global maintenance interrupt enable |
| en_g1_off | input | 1 | Enable: guest Group 1 disabled condition |
| en_g1_on | input | 1 | Enable: guest Group 1 enabled condition |
| en_g0_off | input | 1 | Enable: guest Group 0 disabled condition |
| en_g0_on | input | 1 | Enable: guest Group 0 enabled condition |
| en_nopend | input | 1 | Enable: no-pending condition |
| en_lr_absent | input | 1 | Enable: entry-not-present condition |
| en_underflow | input | 1 | Enable: underflow condition |
| eoi_count | input | EOICNT_W | End-of-interrupt count field |
| vm_grp0_on | input | 1 | Guest Group 0 enable |
| vm_grp1_on | input | 1 | Guest Group 1 enable |
| lr_state | input | 2*N_LR | Packed list entry states |
| eoi_status | input | N_LR | End-of-interrupt status vector |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request (ignored) |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data (ignored) |
| rd_data | output | 32 | Read response, one cycle after request |
| maint_irq | output | 1 | Maintenance interrupt line |

## Verification
An input change shows on `maint_irq` after one clock edge. A read returns the status that was registered when the request was sampled, so that status reflects inputs from two edges earlier. The bench reference model mirrors these two latencies: it updates at each rising edge from the inputs present before that edge, and it keeps the previous status for the read response. All comparisons happen at the falling edge, after both design and model have settled and before new stimulus is applied.

// File: rtl/vmis_pkg.sv
package vmis_pkg;
  localparam int STAT_W = 8;
  localparam int RDATA_W = 32;

  localparam int B_EOI   = 0;
  localparam int B_UNDER = 1;
  localparam int B_ABSNT = 2;
  localparam int B_NOPND = 3;
  localparam int B_G0ON  = 4;
  localparam int B_G0OFF = 5;
  localparam int B_G1ON  = 6;
  localparam int B_G1OFF = 7;

  typedef enum logic [1:0] {
    LR_INVALID = 2'b00,
    LR_PENDING = 2'b01,
    LR_ACTIVE  = 2'b10,
    LR_ACT_PND = 2'b11
  } lr_state_t;

  typedef struct packed {
    logic g1_off;
    logic g1_on;
    logic g0_off;
    logic g0_on;
    logic nopend;
    logic absent;
    logic under;
  } cond_en_t;
endpackage

// File: rtl/vmis_lr_scan.sv
module vmis_lr_scan
  import vmis_pkg::*;
#(
  parameter int N_LR = 4
) (
  input  logic [2*N_LR-1:0] lr_state,
  output logic              none_pending,
  output logic              few_valid
);
  localparam int CNT_W = $clog2(N_LR + 1);

  logic [N_LR-1:0] is_valid;
  logic [N_LR-1:0] is_pend;
  logic [CNT_W-1:0] n_valid;

  for (genvar i = 0; i < N_LR; i++) begin : g_entry
    assign is_valid[i] = lr_state_t'(lr_state[2*i +: 2]) != LR_INVALID;
    assign is_pend[i]  = lr_state_t'(lr_state[2*i +: 2]) == LR_PENDING;
  end

  always_comb begin
    n_valid = '0;
    for (int i = 0; i < N_LR; i++) begin
      n_valid = n_valid + CNT_W'(is_valid[i]);
    end
  end

  assign none_pending = ~|is_pend;
  assign few_valid    = n_valid <= CNT_W'(1);
endmodule

// File: rtl/vmis_cond.sv
module vmis_cond
  import vmis_pkg::*;
#(
  parameter int N_LR     = 4,
  parameter int EOICNT_W = 5
) (
  input  cond_en_t              en,
  input  logic                  vm_grp0_on,
  input  logic                  vm_grp1_on,
  input  logic                  none_pending,
  input  logic                  few_valid,
  input  logic [EOICNT_W-1:0]   eoi_count,
  input  logic [N_LR-1:0]       eoi_status,
  output logic [STAT_W-1:0]     stat_d
);
  always_comb begin
    stat_d          = '0;
    stat_d[B_G1OFF] = en.g1_off & ~vm_grp1_on;
    stat_d[B_G1ON]  = en.g1_on  &  vm_grp1_on;
    stat_d[B_G0OFF] = en.g0_off & ~vm_grp0_on;
    stat_d[B_G0ON]  = en.g0_on  &  vm_grp0_on;
    stat_d[B_NOPND] = en.nopend & none_pending;
    stat_d[B_ABSNT] = en.absent & (eoi_count != '0);
    stat_d[B_UNDER] = en.under  & few_valid;
    stat_d[B_EOI]   = |eoi_status;
  end
endmodule

// File: rtl/vmaint_status.sv
module vmaint_status
  import vmis_pkg::*;
#(
  parameter int              N_LR        = 4,
  parameter int              EOICNT_W    = 5,
  parameter int              ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] STAT_OFFSET = 'h010
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                glob_en,
  input  logic                en_g1_off,
  input  logic                en_g1_on,
  input  logic                en_g0_off,
  input  logic                en_g0_on,
  input  logic                en_nopend,
  input  logic                en_lr_absent,
  input  logic                en_underflow,
  input  logic [EOICNT_W-1:0] eoi_count,
  input  logic                vm_grp0_on,
  input  logic                vm_grp1_on,
  input  logic [2*N_LR-1:0]   lr_state,
  input  logic [N_LR-1:0]     eoi_status,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         rd_data,
  output logic                maint_irq
);
  localparam int PAD_W = RDATA_W - STAT_W;

  cond_en_t          en;
  logic              none_pending, few_valid;
  logic [STAT_W-1:0] stat_d, stat_q;
  logic              irq_q;
  logic [31:0]       rd_q;

  // the register has no writable state; the write side is absorbed here
  logic unused_wr;
  assign unused_wr = ^{bus_wr, bus_wdata};

  assign en = '{g1_off: en_g1_off, g1_on: en_g1_on, g0_off: en_g0_off,
                g0_on: en_g0_on, nopend: en_nopend, absent: en_lr_absent,
                under: en_underflow};

  vmis_lr_scan #(.N_LR(N_LR)) scan_i (
    .lr_state     (lr_state),
    .none_pending (none_pending),
    .few_valid    (few_valid)
  );

  vmis_cond #(.N_LR(N_LR), .EOICNT_W(EOICNT_W)) cond_i (
    .en           (en),
    .vm_grp0_on   (vm_grp0_on),
    .vm_grp1_on   (vm_grp1_on),
    .none_pending (none_pending),
    .few_valid    (few_valid),
    .eoi_count    (eoi_count),
    .eoi_status   (eoi_status),
    .stat_d       (stat_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= glob_en & (|stat_d);
      rd_q   <= (bus_rd && bus_addr == STAT_OFFSET) ? {{PAD_W{1'b0}}, stat_q} : '0;
    end
  end

  assign rd_data   = rd_q;
  assign maint_irq = irq_q;

  // R8: interrupt only with global enable from the previous cycle
  a_r8_irq_needs_glob: assert property (@(posedge clk) disable iff (rst)
    maint_irq |-> $past(glob_en));
  // R8: interrupt only while some status bit is held
  a_r8_irq_needs_stat: assert property (@(posedge clk) disable iff (rst)
    maint_irq |-> (stat_q != '0));
  // R7: any end-of-interrupt bit sets bit 0 one edge later
  a_r7_eoi_seen: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(|eoi_status)) |-> stat_q[B_EOI]);
  // R5: entry-not-present needs a nonzero count
  a_r5_absent_count: assert property (@(posedge clk) disable iff (rst)
    stat_q[B_ABSNT] |-> $past(eoi_count != '0));
  // R9: other offsets return zero
  a_r9_other_zero: assert property (@(posedge clk) disable iff (rst)
    $past(bus_addr != STAT_OFFSET) |-> (rd_data == '0));
  // R1: upper bits never set
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[31:STAT_W] == '0);
endmodule

// File: tb/vmaint_status_tb_top.sv
`timescale 1ns/1ps
module vmaint_status_tb_top;
  localparam int N = 4;
  localparam int EW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic glob_en = 0, en_g1_off = 0, en_g1_on = 0, en_g0_off = 0, en_g0_on = 0;
  logic en_nopend = 0, en_lr_absent = 0, en_underflow = 0;
  logic [EW-1:0] eoi_count = '0;
  logic vm_grp0_on = 0, vm_grp1_on = 0;
  logic [2*N-1:0] lr_state = '0;
  logic [N-1:0] eoi_status = '0;
  logic bus_rd = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] rd_data;
  wire         maint_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  vmaint_status dut_i (
    .clk(clk), .rst(rst), .glob_en(glob_en), .en_g1_off(en_g1_off),
    .en_g1_on(en_g1_on), .en_g0_off(en_g0_off), .en_g0_on(en_g0_on),
    .en_nopend(en_nopend), .en_lr_absent(en_lr_absent),
    .en_underflow(en_underflow), .eoi_count(eoi_count),
    .vm_grp0_on(vm_grp0_on), .vm_grp1_on(vm_grp1_on), .lr_state(lr_state),
    .eoi_status(eoi_status), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .maint_irq(maint_irq)
  );

  always #10 clk = ~clk;

  // reference model: behavioural, integers only
  int m_stat = 0, m_rd = 0, m_irq = 0;
  always @(posedge clk) begin
    int nv, np, ns;
    if (rst) begin
      m_stat = 0; m_rd = 0; m_irq = 0;
    end else begin
      m_rd = (bus_rd && bus_addr == 12'h010) ? m_stat : 0;
      nv = 0; np = 0;
      for (int i = 0; i < N; i++) begin
        int s;
        s = lr_state[2*i +: 2];
        if (s != 0) nv++;
        if (s == 1) np++;
      end
      ns = 0;
      if (en_g1_off && !vm_grp1_on) ns += 128;
      if (en_g1_on && vm_grp1_on)   ns += 64;
      if (en_g0_off && !vm_grp0_on) ns += 32;
      if (en_g0_on && vm_grp0_on)   ns += 16;
      if (en_nopend && np == 0)     ns += 8;
      if (en_lr_absent && eoi_count != 0) ns += 4;
      if (en_underflow && nv < 2)   ns += 2;
      if (eoi_status != 0)          ns += 1;
      m_stat = ns;
      m_irq = (glob_en && ns != 0) ? 1 : 0;
    end
  end

  function automatic string tag_of(int diff);
    if (diff >= 256)          return "R1";
    if ((diff & 'hC0) != 0)   return "R2";
    if ((diff & 'h30) != 0)   return "R3";
    if ((diff & 8) != 0)      return "R4";
    if ((diff & 4) != 0)      return "R5";
    if ((diff & 2) != 0)      return "R6";
    if ((diff & 1) != 0)      return "R7";
    return "R9";
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      int a;
      a = int'(rd_data);
      chk((a == m_rd) ? "R9" : tag_of(a ^ m_rd), a, m_rd);
      chk("R8", int'(maint_irq), m_irq);
    end
  end

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic set_en(input logic [6:0] e);
    {en_g1_off, en_g1_on, en_g0_off, en_g0_on, en_nopend, en_lr_absent, en_underflow} = e;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    // R11: reset clears outputs
    chk("R11", int'(rd_data), 0);
    chk("R11", int'(maint_irq), 0);
    rst = 1'b0;
    bus_rd = 1; bus_addr = 12'h010;
    tick(2);
    // R6: zero valid entries with underflow enabled
    set_en(7'b0000001); glob_en = 1;
    tick(1);
    chk("R11", int'(maint_irq), 1);   // one edge after the change
    tick(1);
    chk("R6", int'(rd_data), 2);
    // R4: all entries active-and-pending: no-pending holds, underflow not
    set_en(7'b0000111); lr_state = 8'b11_11_11_11;
    tick(2);
    chk("R4", int'(rd_data), 8);
    // R4: one pending entry clears bit 3; one valid keeps underflow
    lr_state = 8'b00_00_00_01;
    tick(2);
    chk("R4", int'(rd_data), 2);
    // R6: two valid entries clear underflow
    lr_state = 8'b00_10_00_01; set_en(7'b0000001);
    tick(2);
    chk("R6", int'(rd_data), 0);
    chk("R8", int'(maint_irq), 0);
    // R5: count nonzero
    set_en(7'b0000010); eoi_count = 5'd3;
    tick(2);
    chk("R5", int'(rd_data), 4);
    // R8: global enable off masks line
    glob_en = 0;
    tick(1);
    chk("R8", int'(maint_irq), 0);
    glob_en = 1; eoi_count = 0; set_en(7'b0);
    // R7: end-of-interrupt bit without any enable
    eoi_status = 4'b1000;
    tick(2);
    chk("R7", int'(rd_data), 1);
    eoi_status = 0;
    // R2 / R3: group conditions
    set_en(7'b1111000); vm_grp1_on = 1; vm_grp0_on = 0;
    tick(2);
    chk("R2", int'(rd_data), 'h60);
    vm_grp1_on = 0; vm_grp0_on = 1;
    tick(2);
    chk("R3", int'(rd_data), 'h90);
    // R10: write all ones at the status offset, then read back
    bus_rd = 0; bus_wr = 1; bus_wdata = 32'hFFFF_FFFF;
    tick(1);
    bus_wr = 0; bus_rd = 1;
    tick(1);
    chk("R10", int'(rd_data), 'h90);
    // R9: other offset reads zero
    bus_addr = 12'h014;
    tick(1);
    chk("R9", int'(rd_data), 0);
    // R1: upper bits zero
    bus_addr = 12'h010;
    tick(1);
    chk("R1", int'(rd_data[31:8]), 0);
    // pseudo-random patterns, compared every cycle by the model
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      {en_g1_off, en_g1_on, en_g0_off, en_g0_on, en_nopend, en_lr_absent, en_underflow} = r[6:0];
      glob_en = r[7]; vm_grp0_on = r[8]; vm_grp1_on = r[9];
      lr_state = r[17:10]; eoi_status = (r[18]) ? r[22:19] : 4'b0;
      eoi_count = r[23] ? r[27:23] : 5'd0;
      bus_rd = r[28] | r[29]; bus_wr = r[30];
      bus_addr = r[31] ? 12'h010 : 12'h010 ^ {9'b0, r[2:0]};
      bus_wdata = $urandom;
      tick(1);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule